// File: doc/BRIEF.md
# PWM Power-Trip Protection Unit

This unit sits between a multi-channel complementary PWM generator and the output pads. Four active-high fault inputs arrive asynchronously. Each one passes through its own synchronizer. Each fault can be armed separately. When an armed fault is seen, the unit latches a trip. From then on it replaces every true and complementary PWM output with a safe state, and it keeps doing so whatever the fault inputs do next.

The safe state has two forms. In the first, every output-enable is pulled low so that the pads float. In the second, the outputs stay enabled and the data is forced to programmed levels, with one level for the true outputs and another for the complementary outputs. A single 8-bit control register on a plain write-strobe and read-data bus holds the arming bits, the safe-state choice and the two levels. The same register also returns a read-only trip flag.

Software clears a trip by writing zero to all four arming bits. The clear takes effect only if no armed fault is still present in the synchronized inputs. Clearing the trip also drops the flag.

Top module: `ptrip_unit`

## Requirements
- R1: After synchronous reset every register bit reads 0, no trip is latched, and every output-enable is 1.
- R2: While no trip is latched, `pwm_o` equals `pwm_i`, `pwmn_o` equals `pwmn_i`, and all output-enables are 1.
- R3: Register bit 4+k arms fault input k (k = 0..3). With the bit at 0, fault k has no effect on the outputs or on the trip flag.
- R4: An armed fault held at 1 from just after a clock edge leaves the trip flag and outputs unchanged at the first and second following rising edges, and sets both from the third.
- R5: With register bit 3 at 0 (floating safe state), a latched trip drives every output-enable to 0.
- R6: With register bit 3 at 1 (driven safe state), a latched trip keeps every output-enable at 1 and drives every true output to the inverse of bit 2 and every complementary output to the inverse of bit 1.
- R7: A latched trip persists after every fault input has returned to 0.
- R8: A write whose bits 7:4 are all 0 clears the trip and the flag (bit 0) from the edge of that write, provided no armed synchronized fault is 1.
- R9: A zero-arming write issued while an armed synchronized fault is still 1 leaves the trip latched. The write still loads bits 7:1.
- R10: Register bit 0 is read-only. Writing 1 to it never sets the trip flag.
- R11: Bits 7:1 read back exactly the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value; bit 0 is the trip flag |
| fault_i | input | 4 | Asynchronous active-high fault inputs |
| pwm_i | input | NUM_CH | True PWM waveforms from the generator |
| pwmn_i | input | NUM_CH | Complementary PWM waveforms from the generator |
| pwm_o | output | NUM_CH | True PWM outputs to the pads |
| pwm_oe_o | output | NUM_CH | Output-enable for the true outputs |
| pwmn_o | output | NUM_CH | Complementary outputs to the pads |
| pwmn_oe_o | output | NUM_CH | Output-enable for the complementary outputs |

## Verification
The bench builds the unit with NUM_CH = 4 and SYNC_STAGES = 2. At those values every true and complementary input pattern can be swept while no trip is latched. Every pairing of the 16 arming masks with each of the four fault lines fits in a short run. All eight combinations of safe-state mode and the two levels are checked against a latched trip, and all 256 register write values are read back. Using two synchronizer stages fixes the trip latency at exactly three edges, and the bench samples on each side of that edge.

// File: rtl/ptrip_pkg.sv
package ptrip_pkg;
  localparam int NUM_FLT   = 4;
  localparam int REG_W     = 8;
  localparam int BIT_STAT  = 0;
  localparam int BIT_LVLC  = 1;
  localparam int BIT_LVLT  = 2;
  localparam int BIT_MODE  = 3;
  localparam int BIT_ARM0  = 4;

  typedef enum logic {
    SAFE_FLOAT = 1'b0,
    SAFE_DRIVE = 1'b1
  } safe_mode_e;

  // packed so that it lines up with register bits 7:1
  typedef struct packed {
    logic [NUM_FLT-1:0] arm;
    safe_mode_e         mode;
    logic               lvl_t_n;
    logic               lvl_c_n;
  } ptrip_cfg_t;
endpackage

// File: rtl/ptrip_sync.sv
module ptrip_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ptrip_ctrl.sv
module ptrip_ctrl
  import ptrip_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [NUM_FLT-1:0]  flt_sync,
  output ptrip_cfg_t          cfg_o,
  output logic                tripped_o,
  output logic [REG_W-1:0]    rd_data
);
  ptrip_cfg_t cfg_q;
  logic       trip_q;
  logic       hit;
  logic       clr_req;

  // armed fault present in the synchronized domain
  assign hit     = |(flt_sync & cfg_q.arm);
  // disarm-all write; refused while an armed fault is still present
  assign clr_req = wr_en && (wr_data[REG_W-1:BIT_ARM0] == '0) && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= ptrip_cfg_t'(wr_data[REG_W-1:BIT_LVLC]);
      if (hit)          trip_q <= 1'b1;
      else if (clr_req) trip_q <= 1'b0;
    end
  end

  assign cfg_o     = cfg_q;
  assign tripped_o = trip_q;
  assign rd_data   = {cfg_q, trip_q};
endmodule

// File: rtl/ptrip_override.sv
module ptrip_override
  import ptrip_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              tripped,
  input  ptrip_cfg_t        cfg,
  input  logic [NUM_CH-1:0] pwm_i,
  input  logic [NUM_CH-1:0] pwmn_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_oe_o,
  output logic [NUM_CH-1:0] pwmn_o,
  output logic [NUM_CH-1:0] pwmn_oe_o
);
  logic drive_mode;
  logic safe_t;
  logic safe_c;

  assign drive_mode = (cfg.mode == SAFE_DRIVE);
  // level bits are active-low: 0 selects a high pad
  assign safe_t     = drive_mode & ~cfg.lvl_t_n;
  assign safe_c     = drive_mode & ~cfg.lvl_c_n;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      if (tripped) begin
        pwm_o[c]     = safe_t;
        pwmn_o[c]    = safe_c;
        pwm_oe_o[c]  = drive_mode;
        pwmn_oe_o[c] = drive_mode;
      end else begin
        pwm_o[c]     = pwm_i[c];
        pwmn_o[c]    = pwmn_i[c];
        pwm_oe_o[c]  = 1'b1;
        pwmn_oe_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptrip_unit.sv
module ptrip_unit
  import ptrip_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [3:0]        fault_i,
  input  logic [NUM_CH-1:0] pwm_i,
  input  logic [NUM_CH-1:0] pwmn_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_oe_o,
  output logic [NUM_CH-1:0] pwmn_o,
  output logic [NUM_CH-1:0] pwmn_oe_o
);
  logic [NUM_FLT-1:0] flt_sync;
  ptrip_cfg_t         cfg;
  logic               tripped;

  ptrip_sync #(.W(NUM_FLT), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (fault_i),
    .q_o (flt_sync)
  );

  ptrip_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flt_sync  (flt_sync),
    .cfg_o     (cfg),
    .tripped_o (tripped),
    .rd_data   (rd_data)
  );

  ptrip_override #(.NUM_CH(NUM_CH)) ovr_i (
    .tripped   (tripped),
    .cfg       (cfg),
    .pwm_i     (pwm_i),
    .pwmn_i    (pwmn_i),
    .pwm_o     (pwm_o),
    .pwm_oe_o  (pwm_oe_o),
    .pwmn_o    (pwmn_o),
    .pwmn_oe_o (pwmn_oe_o)
  );
endmodule

// File: rtl/ptrip_unit_chk.sv
module ptrip_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] pwmn_i,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] pwm_oe_o,
  input logic [NUM_CH-1:0] pwmn_o,
  input logic [NUM_CH-1:0] pwmn_oe_o
);
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[0] |-> (pwm_o == pwm_i && pwmn_o == pwmn_i &&
                     pwm_oe_o == '1 && pwmn_oe_o == '1));

  // R5
  float_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && !rd_data[3]) |-> (pwm_oe_o == '0 && pwmn_oe_o == '0));

  // R6
  drive_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && rd_data[3]) |->
      (pwm_oe_o == '1 && pwmn_oe_o == '1 &&
       pwm_o == {NUM_CH{~rd_data[2]}} && pwmn_o == {NUM_CH{~rd_data[1]}}));

  // R7
  trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && !(wr_en && wr_data[7:4] == 4'h0)) |=> rd_data[0]);

  // R11
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7:1] == $past(wr_data[7:1])));
endmodule

bind ptrip_unit ptrip_unit_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pwm_i     (pwm_i),
  .pwmn_i    (pwmn_i),
  .pwm_o     (pwm_o),
  .pwm_oe_o  (pwm_oe_o),
  .pwmn_o    (pwmn_o),
  .pwmn_oe_o (pwmn_oe_o)
);

// File: tb/ptrip_unit_tb_top.sv
module ptrip_unit_tb_top;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_data = '0;
  logic [7:0]     rd_data;
  logic [3:0]     fault_i = '0;
  logic [NCH-1:0] pwm_i = '0;
  logic [NCH-1:0] pwmn_i = '0;
  logic [NCH-1:0] pwm_o, pwm_oe_o, pwmn_o, pwmn_oe_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ptrip_unit #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fault_i(fault_i), .pwm_i(pwm_i), .pwmn_i(pwmn_i),
    .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .pwmn_o(pwmn_o), .pwmn_oe_o(pwmn_oe_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    tick(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {16'h0, pwm_o, pwm_oe_o, pwmn_o, pwmn_oe_o};
  endfunction

  function automatic logic [31:0] pack_exp(input logic [NCH-1:0] a, b, c, d);
    return {16'h0, a, b, c, d};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 reg", {24'h0, rd_data}, 32'h0);
    check("R1 oe", {28'h0, pwm_oe_o & pwmn_oe_o}, 32'hF);

    // R2 full pass-through sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pwm_i = a[3:0];
        pwmn_i = b[3:0];
        #1;
        check("R2 pass", outs(), pack_exp(a[3:0], 4'hF, b[3:0], 4'hF));
      end
    end

    // R3/R4/R8: every arming mask against every fault line, driven mode, t=1 c=0
    pwm_i = 4'h0;
    pwmn_i = 4'hF;
    for (int en = 0; en < 16; en++) begin
      for (int f = 0; f < 4; f++) begin
        logic armed;
        armed = en[f];
        wr({en[3:0], 4'b1010});
        fault_i = 4'b0001 << f;
        tick(2);
        check("R4 not yet", {31'h0, rd_data[0]}, 32'h0);
        tick(1);
        check("R3 flag", {31'h0, rd_data[0]}, {31'h0, armed});
        check("R3 outs", outs(), armed ? pack_exp(4'hF, 4'hF, 4'h0, 4'hF)
                                       : pack_exp(4'h0, 4'hF, 4'hF, 4'hF));
        fault_i = 4'h0;
        tick(3);
        check("R7 hold", {31'h0, rd_data[0]}, {31'h0, armed});
        wr(8'h0A);
        check("R8 clear", {31'h0, rd_data[0]}, 32'h0);
        check("R8 outs", outs(), pack_exp(4'h0, 4'hF, 4'hF, 4'hF));
      end
    end

    // R5/R6: every safe-mode and level combination
    for (int m = 0; m < 8; m++) begin
      logic md, lt, lc;
      md = m[2]; lt = m[1]; lc = m[0];
      wr({4'b0001, m[2:0], 1'b0});
      fault_i = 4'b0001;
      tick(3);
      fault_i = 4'b0000;
      pwm_i = 4'h5;
      pwmn_i = 4'hA;
      tick(3);
      if (md)
        check("R6 drive", outs(), pack_exp({4{~lt}}, 4'hF, {4{~lc}}, 4'hF));
      else
        check("R5 float", {16'h0, 4'h0, pwm_oe_o, 4'h0, pwmn_oe_o}, 32'h0);
      wr(8'h00);
      check("R8 clear m", {31'h0, rd_data[0]}, 32'h0);
    end

    // R9: clear refused while armed fault present
    wr(8'h28);
    fault_i = 4'b0010;
    tick(3);
    check("R9 tripped", {31'h0, rd_data[0]}, 32'h1);
    wr(8'h08);
    check("R9 refused", {31'h0, rd_data[0]}, 32'h1);
    check("R9 loaded", {24'h0, rd_data}, 32'h09);
    fault_i = 4'b0000;
    tick(3);
    wr(8'h00);
    check("R8 after R9", {31'h0, rd_data[0]}, 32'h0);

    // R10/R11: all write values read back, bit 0 never set
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      check("R11 readback", {24'h0, rd_data[7:1], 1'b0}, {24'h0, v[7:1], 1'b0});
      check("R10 ro flag", {31'h0, rd_data[0]}, 32'h0);
    end

    finish_run();
  end
endmodule